// File: doc/BRIEF.md
# Serial Wire Debug Host Transaction Engine

This block sits on the host side of a two-wire debug link and runs one register access at a time against a debug port or an access port. A requester gives it a read/write flag, a port select, a two-bit register index and, for a write, a 32-bit word. The engine forms the 8-bit request header and shifts it out. It releases the data line for a turnaround, reads the target's 3-bit acknowledge and then either moves a 32-bit word with its parity or abandons the data phase. It returns the raw acknowledge, the read word and a parity-mismatch flag.

The serial clock is made from a clock-enable strobe. Each strobe toggles the serial clock, so one bit lasts two strobes. The engine drives its output and output enable only on falling serial-clock edges and samples the line only on rising ones. The turnaround length comes from a configuration input that is captured when a request is accepted. Failures come back at once. The engine never retries and never queues.

Requests arrive on a valid/ready pair. Ready is high only while the engine is idle, so a valid request made while a transaction is in flight is not taken. Results leave on a second valid/ready pair. The response holds steady until the requester takes it, and no new request is accepted before then. That wait is the back-pressure path.

Top module: `swd_host_engine`

## Requirements
- R1: The header is sent LSB first as eight bit slots. Slot 0 is start (1). Slot 1 is the port select (1 = access port). Slot 2 is the direction (1 = read). Slots 3 and 4 are address bits 0 and 1. Slot 5 is parity. Slot 6 is stop (0). Slots 0 to 6 are driven.
- R2: Header slot 5 is 1 exactly when an odd number of slots 1 to 4 are 1.
- R3: The output enable is low during header slot 7, during every turnaround slot, during the three acknowledge slots and during all 33 read-data slots.
- R4: Each turnaround lasts trn_cfg bit slots, with 0 treated as 1. The value is taken when the request is accepted, and later changes to trn_cfg do not affect a transaction already running.
- R5: The acknowledge is sampled LSB first and reported raw on rsp_ack (001 OK, 010 WAIT, 100 FAULT). rsp_proto_err is 1 for any other code.
- R6: When the acknowledge is not OK, the data phase is skipped. One turnaround follows and the transaction ends, 11 + 2T slots in all. rsp_rdata is 0 and rsp_perr is 0.
- R7: On a read with OK, the engine samples 32 data bits LSB first and then a parity bit, followed by one turnaround (44 + 2T slots). rsp_rdata holds the word, and rsp_perr is 1 when the received parity is not the even parity of the word.
- R8: On a write with OK, one turnaround follows the acknowledge. The engine then drives 32 data bits LSB first and then their even parity (44 + 2T slots).
- R9: swclk is low while idle and changes only on a tick. swdio_o and swdio_oe never change at a rising swclk edge.
- R10: req_ready is high only when idle. A response stays valid and unchanged until rsp_ready, and no request is accepted while a response is pending or a transaction runs.
- R11: After reset, req_ready is 1, rsp_valid is 0, swclk is 0, and swdio_oe is 1 with swdio_o at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Clock enable; each pulse is one swclk half period |
| trn_cfg | input | TRN_W | Turnaround length in bit slots (0 means 1) |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Engine idle and able to accept |
| req_rnw | input | 1 | 1 = read, 0 = write |
| req_ap | input | 1 | 1 = access port, 0 = debug port |
| req_addr | input | 2 | Register index (address bits 3:2) |
| req_wdata | input | DATA_W | Write word |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_ack | output | 3 | Raw acknowledge code |
| rsp_proto_err | output | 1 | Acknowledge not one of the three legal codes |
| rsp_rdata | output | DATA_W | Read word (0 unless read with OK) |
| rsp_perr | output | 1 | Read parity mismatch |
| swclk | output | 1 | Serial clock |
| swdio_o | output | 1 | Data line value when driven |
| swdio_oe | output | 1 | Data line drive enable |
| swdio_i | input | 1 | Data line as seen on the pin |

## Verification
The hardest case to reach from the ports is a bit-accurate check of where line ownership changes, that is, which slots are undriven. This depends on the captured turnaround length together with the acknowledge path taken. The bench therefore holds a target model keyed to the count of rising swclk edges. That model answers with a chosen acknowledge, word and optionally corrupted parity, and records the drive state at every rising edge so each slot can be compared with the expected layout. Further directed runs change trn_cfg and raise a second request mid-transaction, and hold off rsp_ready, to show that captured state and back-pressure both behave as specified.

// File: rtl/swd_pkg.sv
package swd_pkg;
  localparam logic [2:0] ACK_OK    = 3'b001;
  localparam logic [2:0] ACK_WAIT  = 3'b010;
  localparam logic [2:0] ACK_FAULT = 3'b100;
  localparam int unsigned HDR_BITS = 8;
  localparam int unsigned ACK_BITS = 3;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_HDR,
    PH_TRN_A,
    PH_ACK,
    PH_RDAT,
    PH_TRN_W,
    PH_WDAT,
    PH_TRN_E,
    PH_DONE
  } phase_e;

  function automatic logic ack_legal(input logic [2:0] a);
    return (a == ACK_OK) || (a == ACK_WAIT) || (a == ACK_FAULT);
  endfunction
endpackage

// File: rtl/swd_clk_phase.sv
module swd_clk_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run,
  output logic swclk,
  output logic rise,
  output logic fall
);
  assign rise = run & tick & ~swclk;
  assign fall = run & tick & swclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      swclk <= 1'b0;
    else if (!run)   swclk <= 1'b0;
    else if (tick)   swclk <= ~swclk;
  end
endmodule

// File: rtl/swd_hdr_pack.sv
module swd_hdr_pack (
  input  logic       rnw,
  input  logic       ap,
  input  logic [1:0] addr,
  output logic [7:0] hdr
);
  logic par;
  assign par = ap ^ rnw ^ addr[0] ^ addr[1];
  // slot 7 (park) is never driven; value is don't-care, kept high
  assign hdr = {1'b1, 1'b0, par, addr[1], addr[0], rnw, ap, 1'b1};
endmodule

// File: rtl/swd_shift_in.sv
module swd_shift_in #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (clr)  q <= '0;
    else if (en)   q <= {din, q[W-1:1]};
  end
endmodule

// File: rtl/swd_host_engine.sv
module swd_host_engine #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TRN_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [TRN_W-1:0]  trn_cfg,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_rnw,
  input  logic              req_ap,
  input  logic [1:0]        req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [2:0]        rsp_ack,
  output logic              rsp_proto_err,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_perr,
  output logic              swclk,
  output logic              swdio_o,
  output logic              swdio_oe,
  input  logic              swdio_i
);
  import swd_pkg::*;

  localparam int unsigned DW_P   = DATA_W + 1;
  localparam int unsigned CNT_W  = $clog2(DW_P + 1);
  localparam int unsigned IDX_W  = $clog2(DATA_W);

  phase_e             ph;
  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   len;
  logic [TRN_W-1:0]   trn_len;
  logic               lat_rnw, lat_ap;
  logic [1:0]         lat_addr;
  logic [DATA_W-1:0]  lat_wdata;
  logic [7:0]         hdr;
  logic [2:0]         ack_q;
  logic [DW_P-1:0]    dat_q;
  logic               run, rise, fall, last, accept, rd_ok;

  assign req_ready = (ph == PH_IDLE);
  assign accept    = req_ready & req_valid;
  assign run       = (ph != PH_IDLE) && (ph != PH_DONE);

  swd_clk_phase u_clk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run),
    .swclk(swclk), .rise(rise), .fall(fall)
  );

  swd_hdr_pack u_hdr (
    .rnw(lat_rnw), .ap(lat_ap), .addr(lat_addr), .hdr(hdr)
  );

  swd_shift_in #(.W(ACK_BITS)) u_ack (
    .clk(clk), .rst_n(rst_n), .clr(accept),
    .en(rise && ph == PH_ACK), .din(swdio_i), .q(ack_q)
  );

  swd_shift_in #(.W(DW_P)) u_dat (
    .clk(clk), .rst_n(rst_n), .clr(accept),
    .en(rise && ph == PH_RDAT), .din(swdio_i), .q(dat_q)
  );

  always_comb begin
    unique case (ph)
      PH_HDR:                     len = CNT_W'(HDR_BITS);
      PH_ACK:                     len = CNT_W'(ACK_BITS);
      PH_RDAT, PH_WDAT:           len = CNT_W'(DW_P);
      PH_TRN_A, PH_TRN_W, PH_TRN_E: len = CNT_W'(trn_len);
      default:                    len = CNT_W'(1);
    endcase
  end
  assign last = (cnt == len - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= PH_IDLE;
      cnt       <= '0;
      trn_len   <= TRN_W'(1);
      lat_rnw   <= 1'b0;
      lat_ap    <= 1'b0;
      lat_addr  <= '0;
      lat_wdata <= '0;
    end else begin
      unique case (ph)
        PH_IDLE: if (req_valid) begin
          ph        <= PH_HDR;
          cnt       <= '0;
          trn_len   <= (trn_cfg == '0) ? TRN_W'(1) : trn_cfg;
          lat_rnw   <= req_rnw;
          lat_ap    <= req_ap;
          lat_addr  <= req_addr;
          lat_wdata <= req_wdata;
        end
        PH_DONE: if (rsp_ready) ph <= PH_IDLE;
        default: if (fall) begin
          if (!last) cnt <= cnt + CNT_W'(1);
          else begin
            cnt <= '0;
            unique case (ph)
              PH_HDR:   ph <= PH_TRN_A;
              PH_TRN_A: ph <= PH_ACK;
              PH_ACK:   ph <= (ack_q != ACK_OK) ? PH_TRN_E :
                              (lat_rnw ? PH_RDAT : PH_TRN_W);
              PH_RDAT:  ph <= PH_TRN_E;
              PH_TRN_W: ph <= PH_WDAT;
              default:  ph <= PH_DONE;
            endcase
          end
        end
      endcase
    end
  end

  // line drive: changes only when ph/cnt change, i.e. on falling edges
  always_comb begin
    swdio_oe = 1'b0;
    swdio_o  = 1'b0;
    unique case (ph)
      PH_IDLE, PH_DONE: swdio_oe = 1'b1;
      PH_HDR: begin
        swdio_oe = (cnt != CNT_W'(HDR_BITS - 1));
        swdio_o  = swdio_oe & hdr[cnt[2:0]];
      end
      PH_WDAT: begin
        swdio_oe = 1'b1;
        swdio_o  = (cnt == CNT_W'(DATA_W)) ? ^lat_wdata
                                            : lat_wdata[cnt[IDX_W-1:0]];
      end
      default: ;
    endcase
  end

  assign rd_ok         = lat_rnw && (ack_q == ACK_OK);
  assign rsp_valid     = (ph == PH_DONE);
  assign rsp_ack       = ack_q;
  assign rsp_proto_err = ~ack_legal(ack_q);
  assign rsp_rdata     = rd_ok ? dat_q[DATA_W-1:0] : '0;
  assign rsp_perr      = rd_ok & (^dat_q);
endmodule

// File: rtl/swd_host_chk.sv
module swd_host_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TRN_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic [TRN_W-1:0]  trn_cfg,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_rnw,
  input logic              req_ap,
  input logic [1:0]        req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [2:0]        rsp_ack,
  input logic              rsp_proto_err,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_perr,
  input logic              swclk,
  input logic              swdio_o,
  input logic              swdio_oe,
  input logic              swdio_i
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;

  p_swclk_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && (swclk != $past(swclk)) |-> $past(tick));

  p_idle_clk_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !swclk);

  p_no_drive_change_on_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $rose(swclk) |-> $stable(swdio_o) && $stable(swdio_oe));

  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_ack)
                                && $stable(rsp_rdata) && $stable(rsp_perr));

  p_busy_when_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  p_ok_is_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_ack == 3'b001) |-> !rsp_proto_err);

  p_no_data_on_fail_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_ack != 3'b001) |-> !rsp_perr && (rsp_rdata == '0));
endmodule

bind swd_host_engine swd_host_chk #(.DATA_W(DATA_W), .TRN_W(TRN_W)) u_chk (.*);

// File: tb/sim_swd_host_engine.sv
module sim_swd_host_engine;
  localparam int DW = 32;

  typedef struct packed {
    logic        rnw;
    logic        ap;
    logic [1:0]  addr;
    logic [1:0]  trn;
    logic [2:0]  ack;
    logic        flip;
    logic [31:0] data;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 2'd0, 2'd1, 3'b001, 1'b0, 32'h1BA0_1477},
    '{1'b1, 1'b1, 2'd3, 2'd2, 3'b001, 1'b1, 32'hDEAD_BEEF},
    '{1'b0, 1'b0, 2'd1, 2'd0, 3'b001, 1'b0, 32'hA5A5_0F0F},
    '{1'b0, 1'b1, 2'd2, 2'd3, 3'b010, 1'b0, 32'h1234_5678},
    '{1'b1, 1'b1, 2'd1, 2'd1, 3'b100, 1'b0, 32'h0BAD_F00D},
    '{1'b1, 1'b0, 2'd2, 2'd2, 3'b111, 1'b0, 32'h5555_AAAA},
    '{1'b0, 1'b0, 2'd3, 2'd2, 3'b001, 1'b0, 32'hFFFF_FFFF},
    '{1'b1, 1'b0, 2'd0, 2'd0, 3'b001, 1'b0, 32'h0000_0001}
  };

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic [1:0] trn_cfg = 2'd1;
  logic req_valid = 1'b0, req_rnw = 1'b0, req_ap = 1'b0;
  logic [1:0] req_addr = 2'd0;
  logic [DW-1:0] req_wdata = '0;
  logic rsp_ready = 1'b1;
  logic req_ready, rsp_valid, rsp_proto_err, rsp_perr, swclk, swdio_o, swdio_oe, swdio_i;
  logic [2:0] rsp_ack;
  logic [DW-1:0] rsp_rdata;

  int total = 0, bad = 0, cyc = 0;

  // target model state
  int rc = 0;
  int tT = 1;
  logic [2:0] t_ack = 3'b001;
  logic [31:0] t_data = '0;
  logic t_flip = 1'b0, t_rd = 1'b0;
  logic tr_oe [128];
  logic tr_o  [128];

  swd_host_engine u0 (.*);

  always #5 clk = ~clk;
  initial forever begin @(negedge clk); tick = ~tick; end
  initial forever begin @(posedge clk); cyc++; end

  function automatic logic tgt_bit(input int i);
    if (i >= 8 + tT && i < 11 + tT) return t_ack[i - 8 - tT];
    if (t_rd && t_ack == 3'b001 && i >= 11 + tT && i < 43 + tT) return t_data[i - 11 - tT];
    if (t_rd && t_ack == 3'b001 && i == 43 + tT) return (^t_data) ^ t_flip;
    return 1'b1;
  endfunction
  assign swdio_i = tgt_bit(rc);

  always @(posedge swclk) begin
    if (rc < 128) begin tr_oe[rc] = swdio_oe; tr_o[rc] = swdio_o; end
    rc = rc + 1;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wait_rsp();
    while (!rsp_valid && cyc < 100000) @(negedge clk);
  endtask

  // poke: raise a different request mid-run; trn_chg: alter trn_cfg after accept; hold: delay rsp_ready
  task automatic run_txn(input vec_t v, input bit poke, input bit trn_chg, input bit hold);
    int T, exp_n, base;
    bit ok_all;
    logic [7:0] hdr;
    logic par;
    T = (v.trn == 0) ? 1 : int'(v.trn);
    @(negedge clk);
    tT = T; t_ack = v.ack; t_data = v.data; t_flip = v.flip; t_rd = v.rnw; rc = 0;
    trn_cfg = v.trn; req_rnw = v.rnw; req_ap = v.ap; req_addr = v.addr;
    req_wdata = v.data; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (trn_chg) trn_cfg = 2'd3;
    if (hold) rsp_ready = 1'b0;
    if (poke) begin
      repeat (6) @(negedge clk);
      req_rnw = ~v.rnw; req_ap = ~v.ap; req_addr = ~v.addr; req_valid = 1'b1;
      chk(req_ready == 1'b0, "R10 ready low while busy", req_ready, 0);
    end
    wait_rsp();
    if (poke) req_valid = 1'b0;
    par = v.ap ^ v.rnw ^ v.addr[0] ^ v.addr[1];
    hdr = {1'b1, 1'b0, par, v.addr[1], v.addr[0], v.rnw, v.ap, 1'b1};
    ok_all = 1;
    for (int i = 0; i < 7; i++)
      if (i != 5 && (tr_oe[i] !== 1'b1 || tr_o[i] !== hdr[i])) ok_all = 0;
    chk(ok_all, "R1 header slots", {tr_o[6], tr_o[4], tr_o[3], tr_o[2], tr_o[1], tr_o[0]},
        {hdr[6], hdr[4:0]});
    chk(tr_oe[5] === 1'b1 && tr_o[5] === par, "R2 header parity", tr_o[5], par);
    ok_all = 1;
    for (int i = 7; i < 11 + T; i++) if (tr_oe[i] !== 1'b0) ok_all = 0;
    chk(ok_all, "R3 park/turnaround/ack undriven", 0, 0);
    exp_n = (v.ack != 3'b001) ? 11 + 2 * T : 44 + 2 * T;
    chk(rc == exp_n, (v.ack != 3'b001) ? "R6 slot count" : "R4 slot count", rc, exp_n);
    chk(rsp_ack == v.ack, "R5 ack", rsp_ack, v.ack);
    chk(rsp_proto_err == !(v.ack == 3'b001 || v.ack == 3'b010 || v.ack == 3'b100),
        "R5 proto flag", rsp_proto_err, 0);
    if (v.ack != 3'b001) begin
      chk(rsp_rdata == 0 && rsp_perr == 0, "R6 no data", rsp_rdata, 0);
    end else if (v.rnw) begin
      chk(rsp_rdata == v.data, "R7 read data", rsp_rdata, v.data);
      chk(rsp_perr == v.flip, "R7 parity flag", rsp_perr, v.flip);
      ok_all = 1;
      for (int i = 11 + T; i < exp_n; i++) if (tr_oe[i] !== 1'b0) ok_all = 0;
      chk(ok_all, "R3 read slots undriven", 0, 0);
    end else begin
      base = 11 + 2 * T;
      ok_all = 1;
      for (int i = 11 + T; i < base; i++) if (tr_oe[i] !== 1'b0) ok_all = 0;
      for (int i = 0; i < 32; i++)
        if (tr_oe[base + i] !== 1'b1 || tr_o[base + i] !== v.data[i]) ok_all = 0;
      if (tr_oe[base + 32] !== 1'b1 || tr_o[base + 32] !== ^v.data) ok_all = 0;
      chk(ok_all, "R8 write slots", 0, 0);
    end
    if (hold) begin
      repeat (8) @(negedge clk);
      chk(rsp_valid && rsp_ack == v.ack && !req_ready && !swclk, "R10 response held",
          rsp_valid, 1);
      rsp_ready = 1'b1;
    end
    @(negedge clk);
    @(negedge clk);
    chk(req_ready && !rsp_valid && swdio_oe && !swclk && rc == exp_n,
        "R10 idle after response", rc, exp_n);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1 && rsp_valid == 0 && swclk == 0 && swdio_oe == 1 && swdio_o == 0,
        "R11 reset state", {req_ready, rsp_valid, swclk, swdio_oe, swdio_o}, 5'b10010);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(swclk == 0 && rc == 0, "R9 idle clock low", swclk, 0);
    for (int k = 0; k < NV; k++) run_txn(VEC[k], 1'b0, 1'b0, 1'b0);
    // R4: trn_cfg changed after acceptance must not alter the run
    run_txn('{1'b1, 1'b0, 2'd1, 2'd1, 3'b001, 1'b0, 32'hCAFE_0001}, 1'b0, 1'b1, 1'b0);
    // R10: second request raised while busy is not taken; response back-pressure
    run_txn('{1'b0, 1'b1, 2'd0, 2'd2, 3'b001, 1'b0, 32'h0F0F_1234}, 1'b1, 1'b0, 1'b1);
    run_txn('{1'b1, 1'b1, 2'd3, 2'd3, 3'b100, 1'b0, 32'h0}, 1'b1, 1'b0, 1'b1);
    if (cyc >= 100000) chk(1'b0, "watchdog", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    bad++; total++;
    $display("FAIL watchdog act=%0d exp<150000", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule